// File: doc/BRIEF.md
# Multiplexed Segment LCD Drive Sequencer

This block sequences the common and segment drive of a multiplexed segment LCD with 1/2, 1/3 or 1/4 duty. It stores one 56-bit row of display bits per common line, steps through the common phases once per frame, and gives every pin a symbolic drive-level code. An analog stage outside the block turns each code into a voltage.

Every common phase opens with a short key-scan window. During that window the first eight segment pins act as key sources and are raised one after another. A display-off state and an output-enable input both force all pins to the idle top level. When LED mode is selected, the upper eight segment pins become LED lines with inverted polarity.

The clock is the divided oscillator. The host configures the block through three write strobes: mode, status and row write. Drive polarity reverses every frame, so the panel sees no net DC.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: After reset the display is off, the duty code is 00 and the divider code is 00. Every common and segment level is LVL_FULL, `led_on` is 0 and `key_slot` is 0. The level codes are LVL_GND=0, LVL_THIRD=1, LVL_HALF=2, LVL_TWO3=3 and LVL_FULL=4, three bits each. Pin k occupies bits [3k+2:3k] of its bus.
- R2: A phase lasts BASE_DIV<<div clocks. A frame has 4 phases for duty code 00, 3 for 01, and 2 for 10 or 11. `phase` counts 0 upward and wraps after the last phase. Polarity starts at 0 after reset or a mode change and reverses at each frame wrap.
- R3: With duty code 00 or 01 (1/3 bias), and outside the key window, the common whose index equals `phase` is LVL_FULL at polarity 0 and LVL_GND at polarity 1. The other commons are LVL_THIRD, or LVL_TWO3 at polarity 1. A segment whose bit is 1 is LVL_GND, or LVL_FULL at polarity 1. A segment whose bit is 0 is LVL_TWO3, or LVL_THIRD at polarity 1.
- R4: With duty code 10 or 11 (1/2 bias), the selected common and the lit segments follow R3. Non-selected commons are LVL_HALF. Dark segments are LVL_FULL at polarity 0 and LVL_GND at polarity 1.
- R5: While the display is on, the first KEY_CLKS clocks of each phase form the key window and `key_slot` is 1. All commons are LVL_HALF. Key-source segment j (j<8) is LVL_FULL when j equals the in-phase count divided by 2, and LVL_GND otherwise. All other segments are LVL_GND.
- R6: A row write stores `row_data` into row `row_addr`. Bit k drives segment k while common `row_addr` is selected. Rows beyond the active duty never reach the pins.
- R7: While `oe` is 0, every common and segment is LVL_FULL and `led_on` is 0. The stored rows survive, and the display resumes unchanged when `oe` returns to 1.
- R8: Status code 10 turns the display on and 00 turns it off. Codes 01 and 11 change nothing. While the display is off, all pins are LVL_FULL and no key window occurs.
- R9: A mode write whose duty or divider differs from the current setting loads it, turns the display off and restarts the phase and polarity counting. A mode write that repeats the current setting has no effect.
- R10: With `led_mode` at 1, segments 48 to 55 are LVL_FULL. With the display on and `oe` at 1, `led_on[i]` equals the inverse of row 0 bit 48+i. Otherwise `led_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe | input | 1 | Output enable; low forces all pins to the top level |
| led_mode | input | 1 | Upper eight segments serve as LED lines |
| mode_we | input | 1 | Mode write strobe |
| mode_duty | input | 2 | Duty code (00 1/4, 01 1/3, 1x 1/2) |
| mode_div | input | 2 | Frame divider code |
| status_we | input | 1 | Status write strobe |
| status_disp | input | 2 | Display code (10 on, 00 off) |
| row_we | input | 1 | Row write strobe |
| row_addr | input | 2 | Row (common) address |
| row_data | input | 56 | Row display bits, bit k to segment k |
| com_lvl | output | 12 | Common level codes, 3 bits per common |
| seg_lvl | output | 168 | Segment level codes, 3 bits per segment |
| led_on | output | 8 | LED line on |
| key_slot | output | 1 | Key window active |
| phase | output | 2 | Current common phase |

## Verification
The bench sweeps every duty code and every divider code over whole frames and predicts each pin in every cycle from the cycle count. A wrong phase length, frame wrap or polarity toggle would shift a selected common or a lit segment, and the prediction catches it at once. Key-window edges are checked cycle by cycle: a window one clock too long, or a key source raised off by one, would show the wrong pin at LVL_FULL. Repeated and changed mode writes, the ignored status codes 01 and 11, output-enable dropouts with later resumption, and inverted LED polarity are each exercised. Each of these would leave a stray level or a lost display if handled wrongly.

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer #(
  parameter int SEG_W    = 56,
  parameter int LED_W    = 8,
  parameter int KS_W     = 8,
  parameter int KEY_CLKS = 16,
  parameter int BASE_DIV = 128,
  parameter int LVL_W    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   oe,
  input  logic                   led_mode,
  input  logic                   mode_we,
  input  logic [1:0]             mode_duty,
  input  logic [1:0]             mode_div,
  input  logic                   status_we,
  input  logic [1:0]             status_disp,
  input  logic                   row_we,
  input  logic [1:0]             row_addr,
  input  logic [SEG_W-1:0]       row_data,
  output logic [4*LVL_W-1:0]     com_lvl,
  output logic [SEG_W*LVL_W-1:0] seg_lvl,
  output logic [LED_W-1:0]       led_on,
  output logic                   key_slot,
  output logic [1:0]             phase
);
  localparam int ROWS   = 4;
  localparam int CNT_W  = $clog2(BASE_DIV * 8);
  localparam int KS_LEN = KEY_CLKS / KS_W;
  localparam int KS_IW  = $clog2(KS_W);
  localparam int LED_LO = SEG_W - LED_W;
  localparam logic [LVL_W-1:0] LVL_GND   = LVL_W'(0);
  localparam logic [LVL_W-1:0] LVL_THIRD = LVL_W'(1);
  localparam logic [LVL_W-1:0] LVL_HALF  = LVL_W'(2);
  localparam logic [LVL_W-1:0] LVL_TWO3  = LVL_W'(3);
  localparam logic [LVL_W-1:0] LVL_FULL  = LVL_W'(4);

  logic [1:0]       duty_q, div_q, ph;
  logic             disp_on, pol;
  logic [CNT_W-1:0] cnt;
  logic [SEG_W-1:0] rows [ROWS];

  wire [1:0]       nph_m1  = (duty_q == 2'd0) ? 2'd3 : (duty_q == 2'd1) ? 2'd2 : 2'd1;
  wire [CNT_W-1:0] plen_m1 = CNT_W'((BASE_DIV << div_q) - 1);
  wire             bias3   = ~duty_q[1];
  wire             mode_chg = mode_we && ({mode_duty, mode_div} != {duty_q, div_q});
  wire [KS_IW-1:0] ks_idx  = KS_IW'(cnt / CNT_W'(KS_LEN));
  wire             live    = oe && disp_on;

  assign key_slot = disp_on && (cnt < CNT_W'(KEY_CLKS));
  assign phase    = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= 2'd0; div_q <= 2'd0; disp_on <= 1'b0;
      cnt <= '0; ph <= 2'd0; pol <= 1'b0;
    end else if (mode_chg) begin
      duty_q <= mode_duty; div_q <= mode_div; disp_on <= 1'b0;
      cnt <= '0; ph <= 2'd0; pol <= 1'b0;
    end else begin
      if (status_we) begin
        if (status_disp == 2'b10) disp_on <= 1'b1;
        else if (status_disp == 2'b00) disp_on <= 1'b0;
      end
      if (cnt == plen_m1) begin
        cnt <= '0;
        if (ph == nph_m1) begin
          ph  <= 2'd0;
          pol <= ~pol;
        end else begin
          ph <= ph + 2'd1;
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rows[r] <= '0;
    end else if (row_we) begin
      rows[row_addr] <= row_data;
    end
  end

  always_comb begin
    for (int c = 0; c < ROWS; c++) begin
      if (!live)              com_lvl[c*LVL_W +: LVL_W] = LVL_FULL;
      else if (key_slot)      com_lvl[c*LVL_W +: LVL_W] = LVL_HALF;
      else if (2'(c) == ph)   com_lvl[c*LVL_W +: LVL_W] = pol ? LVL_GND : LVL_FULL;
      else if (bias3)         com_lvl[c*LVL_W +: LVL_W] = pol ? LVL_TWO3 : LVL_THIRD;
      else                    com_lvl[c*LVL_W +: LVL_W] = LVL_HALF;
    end
  end

  always_comb begin
    for (int s = 0; s < SEG_W; s++) begin
      if (!live || (led_mode && s >= LED_LO))
        seg_lvl[s*LVL_W +: LVL_W] = LVL_FULL;
      else if (key_slot)
        seg_lvl[s*LVL_W +: LVL_W] = (s < KS_W && KS_IW'(s) == ks_idx) ? LVL_FULL : LVL_GND;
      else if (rows[ph][s])
        seg_lvl[s*LVL_W +: LVL_W] = pol ? LVL_FULL : LVL_GND;
      else if (bias3)
        seg_lvl[s*LVL_W +: LVL_W] = pol ? LVL_THIRD : LVL_TWO3;
      else
        seg_lvl[s*LVL_W +: LVL_W] = pol ? LVL_GND : LVL_FULL;
    end
  end

  assign led_on = (live && led_mode) ? ~rows[0][LED_LO +: LED_W] : '0;

  logic [ROWS-1:0] com_ext;
  always_comb
    for (int c = 0; c < ROWS; c++)
      com_ext[c] = (com_lvl[c*LVL_W +: LVL_W] == LVL_FULL) || (com_lvl[c*LVL_W +: LVL_W] == LVL_GND);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ph <= nph_m1); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != $past(ph)) && !$past(mode_chg) |-> $past(cnt) == $past(plen_m1)); // R2
  AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_chg) && $past(cnt) == $past(plen_m1) && $past(ph) == $past(nph_m1) |-> pol != $past(pol)); // R2
  AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    oe && disp_on && !key_slot |-> $countones(com_ext) == 1); // R3
  AST_KEY_COM_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    key_slot && oe |-> com_lvl == {ROWS{LVL_HALF}}); // R5
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> seg_lvl == {SEG_W{LVL_FULL}} && led_on == '0); // R7
  AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !key_slot && com_lvl == {ROWS{LVL_FULL}}); // R9
endmodule

// File: tb/test_lcd_mux_sequencer.sv
module test_lcd_mux_sequencer;
  logic clk = 1'b0, rst_n = 1'b0, oe = 1'b1, led_mode = 1'b0;
  logic mode_we = 1'b0, status_we = 1'b0, row_we = 1'b0;
  logic [1:0] mode_duty = 2'd0, mode_div = 2'd0, status_disp = 2'd0, row_addr = 2'd0;
  logic [55:0] row_data = '0;
  logic [11:0] com_lvl;
  logic [167:0] seg_lvl;
  logic [7:0] led_on;
  logic key_slot;
  logic [1:0] phase;

  int checks = 0, errors = 0;
  int n = 0;
  logic [1:0] m_duty = 2'd0, m_div = 2'd0;
  logic m_on = 1'b0;
  logic [55:0] rows [4];

  always #5 clk = ~clk;

  lcd_mux_sequencer i_lcd_mux_sequencer (
    .clk(clk), .rst_n(rst_n), .oe(oe), .led_mode(led_mode),
    .mode_we(mode_we), .mode_duty(mode_duty), .mode_div(mode_div),
    .status_we(status_we), .status_disp(status_disp),
    .row_we(row_we), .row_addr(row_addr), .row_data(row_data),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .led_on(led_on),
    .key_slot(key_slot), .phase(phase));

  always @(posedge clk) begin
    if (!rst_n) begin
      n <= 0; m_duty <= 2'd0; m_div <= 2'd0; m_on <= 1'b0;
    end else if (mode_we && {mode_duty, mode_div} != {m_duty, m_div}) begin
      n <= 0; m_duty <= mode_duty; m_div <= mode_div; m_on <= 1'b0;
    end else begin
      n <= n + 1;
      if (status_we && status_disp == 2'b10) m_on <= 1'b1;
      if (status_we && status_disp == 2'b00) m_on <= 1'b0;
    end
  end

  task automatic check(input string tag_in);
    int nph, plen, t, ph, pol;
    logic b3, live, ks;
    logic [11:0] ec;
    logic [167:0] es;
    logic [7:0] el;
    string tag;
    nph  = (m_duty == 0) ? 4 : (m_duty == 1) ? 3 : 2;
    plen = 128 << m_div;
    t    = n % plen;
    ph   = (n / plen) % nph;
    pol  = (n / (plen * nph)) % 2;
    b3   = (m_duty < 2);
    live = oe && m_on;
    ks   = m_on && (t < 16);
    for (int c = 0; c < 4; c++)
      ec[c*3 +: 3] = !live ? 3'd4 : ks ? 3'd2 : (c == ph) ? (pol ? 3'd0 : 3'd4)
                   : b3 ? (pol ? 3'd3 : 3'd1) : 3'd2;
    for (int s = 0; s < 56; s++)
      es[s*3 +: 3] = (!live || (led_mode && s >= 48)) ? 3'd4
                   : ks ? ((s < 8 && s == t / 2) ? 3'd4 : 3'd0)
                   : rows[ph][s] ? (pol ? 3'd4 : 3'd0)
                   : b3 ? (pol ? 3'd1 : 3'd3) : (pol ? 3'd0 : 3'd4);
    el = (live && led_mode) ? ~rows[0][55:48] : 8'h00;
    tag = tag_in;
    if (tag == "") tag = ks ? "R5" : b3 ? "R3" : "R4";
    checks++;
    if (com_lvl !== ec || seg_lvl !== es || led_on !== el || key_slot !== ks || phase !== 2'(ph)) begin
      errors++;
      $display("FAIL %s n=%0d com=%h exp=%h seg=%h exp=%h led=%h exp=%h key=%b exp=%b ph=%0d exp=%0d",
               tag, n, com_lvl, ec, seg_lvl, es, led_on, el, key_slot, ks, phase, ph);
    end
  endtask

  task automatic run(input int k, input string tag);
    repeat (k) begin
      @(posedge clk); #2;
      check(tag);
    end
  endtask

  task automatic set_mode(input logic [1:0] d, input logic [1:0] v);
    @(negedge clk); mode_we = 1'b1; mode_duty = d; mode_div = v;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic set_status(input logic [1:0] code);
    @(negedge clk); status_we = 1'b1; status_disp = code;
    @(negedge clk); status_we = 1'b0;
  endtask

  task automatic write_row(input logic [1:0] a, input logic [55:0] v);
    @(negedge clk); row_we = 1'b1; row_addr = a; row_data = v;
    @(negedge clk); row_we = 1'b0;
    rows[a] = v;
  endtask

  task automatic main;
    for (int r = 0; r < 4; r++) rows[r] = '0;
    repeat (3) @(posedge clk);
    #2 check("R1");
    @(negedge clk) rst_n = 1'b1;
    run(4, "R1");
    write_row(2'd0, 56'hA55AF00F33CC81);
    write_row(2'd1, 56'h0123456789ABCD);
    write_row(2'd2, 56'hFEDCBA98765432);
    write_row(2'd3, 56'hFF00FF00FF00FF);
    run(2, "R6");
    set_status(2'b10);
    run(8, "R8");
    set_mode(2'd0, 2'd0);
    run(40, "R9");
    run(2 * 512, "");
    for (int d = 1; d < 4; d++) begin
      set_mode(2'(d), 2'd0);
      run(3, "R9");
      set_status(2'b10);
      run(2 * 128 * ((d == 1) ? 3 : 2), "");
    end
    for (int v = 1; v < 4; v++) begin
      set_mode(2'd2, 2'(v));
      set_status(2'b10);
      run(2 * (128 << v) + 5, "R2");
    end
    set_mode(2'd0, 2'd0);
    set_status(2'b10);
    write_row(2'd3, 56'h00FF00FF00FF00);
    run(512, "R6");
    @(negedge clk) oe = 1'b0;
    run(40, "R7");
    @(negedge clk) oe = 1'b1;
    run(520, "R7");
    set_status(2'b01);
    run(20, "R8");
    set_status(2'b11);
    run(20, "R8");
    set_status(2'b00);
    run(60, "R8");
    set_status(2'b10);
    @(negedge clk) led_mode = 1'b1;
    run(1030, "R10");
    @(negedge clk) oe = 1'b0;
    run(10, "R10");
    @(negedge clk) oe = 1'b1;
    set_mode(2'd1, 2'd1);
    run(30, "R9");
    set_status(2'b10);
    run(2 * 3 * 256, "R10");
  endtask

  initial begin
    fork
      main;
      begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule